// File: doc/BRIEF.md
# Split-Word Indirect Register Bridge

This block lets a host that only issues 32-bit register writes and reads reach a bank of 64-bit engine registers. The host sees a small register window: two 32-bit data halves, a command word and a status word. To write an engine register, the host fills both halves and then writes a command word with its top bit set. The bridge then issues a single 64-bit write to the engine. To read, the host writes a command word with the top bit clear. When the engine answers, the 64-bit value lands in the two halves, where the host picks it up.

The engine side is a request stream with valid/ready and a response strobe for reads. A request holds its index, direction and data unchanged while valid is high and ready is low. The bridge never refuses a response while a read is outstanding. A command aimed outside the implemented engine range raises a sticky error flag in the status word. Writing the clear register removes the flag and zeroes the staged halves. The engine registers are not touched by that write.

Top module: `sib_bridge`

## Requirements
- R1: After reset, both data halves and the status word read 0 and `req_valid` is low.
- R2: A host write at offset 0x00 sets the upper half (bits 63:32) and a write at 0x04 sets the lower half (bits 31:0). The host reads each half back at the same offset.
- R3: A command write at 0x08 with bit 31 = 1 and an in-range address issues exactly one engine request. That request has `req_write` = 1, `req_idx` equal to the address minus `ENG_BASE`, and `req_wdata` = {upper half, lower half} as staged when the command arrived. No engine register changes before the command is written.
- R4: A command write with bit 31 = 0 and an in-range address issues one read request. When `rsp_valid` arrives, offset 0x00 returns `rsp_rdata[63:32]` and offset 0x04 returns `rsp_rdata[31:0]`.
- R5: Status bit 0 (busy) reads 1 from the cycle after an accepted command until the write handshake completes or the read response arrives. A command written while busy is ignored: it produces no request and no error.
- R6: A command whose address bits 30:0 lie outside [`ENG_BASE`, `ENG_BASE`+`ENG_REGS`) sets status bit 31 (error), issues no request and leaves busy at 0.
- R7: The error bit stays set through later valid commands until any write to offset 0x18. That write clears the error bit and both halves and changes no engine register.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_idx` and `req_wdata` hold their values.
- R9: Offset 0x20 and every unassigned offset read as 0, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 6 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| req_valid | output | 1 | Engine request valid |
| req_ready | input | 1 | Engine accepts request |
| req_write | output | 1 | Request direction, 1 = write |
| req_idx | output | IDX_W | Engine register index |
| req_wdata | output | 64 | 64-bit write value |
| rsp_valid | input | 1 | Read response strobe |
| rsp_rdata | input | 64 | Read response value |

## Verification
A stuck or wrongly sequenced command state shows at the host port within one cycle of the command write: the busy bit fails to rise, or it never falls, so the host's poll of the status word stalls. A misordered or stale staging register shows up in the engine write data at the handshake, or in the halves read back right after the response. A sticky error that is set or cleared wrongly is visible in the next status read.

// File: rtl/sib_pkg.sv
package sib_pkg;
  localparam logic [5:0] OFS_WIN_HI = 6'h00;
  localparam logic [5:0] OFS_WIN_LO = 6'h04;
  localparam logic [5:0] OFS_CMD    = 6'h08;
  localparam logic [5:0] OFS_CLR    = 6'h18;
  localparam logic [5:0] OFS_STAT   = 6'h1C;
  localparam logic [5:0] OFS_IRQ    = 6'h20;
  localparam int STAT_ERR_BIT  = 31;
  localparam int STAT_BUSY_BIT = 0;
  localparam int CMD_WR_BIT    = 31;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_AWAIT} sib_state_e;
endpackage

// File: rtl/sib_host_regs.sv
module sib_host_regs
  import sib_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_wr,
  input  logic [5:0]  hst_addr,
  input  logic [31:0] hst_wdata,
  output logic [31:0] hst_rdata,
  input  logic        busy,
  input  logic        err_set,
  input  logic        load_en,
  input  logic [63:0] load_data,
  output logic [31:0] win_hi,
  output logic [31:0] win_lo,
  output logic        err_flag,
  output logic        cmd_fire,
  output logic [31:0] cmd_word
);
  logic clr_wr;
  assign clr_wr   = hst_wr && (hst_addr == OFS_CLR);
  assign cmd_fire = hst_wr && (hst_addr == OFS_CMD);
  assign cmd_word = hst_wdata;

  // Priority: clear register, then engine read data, then host half writes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_hi   <= '0;
      win_lo   <= '0;
      err_flag <= 1'b0;
    end else if (clr_wr) begin
      win_hi   <= '0;
      win_lo   <= '0;
      err_flag <= 1'b0;
    end else begin
      if (load_en) begin
        win_hi <= load_data[63:32];
        win_lo <= load_data[31:0];
      end else if (hst_wr && hst_addr == OFS_WIN_HI) begin
        win_hi <= hst_wdata;
      end else if (hst_wr && hst_addr == OFS_WIN_LO) begin
        win_lo <= hst_wdata;
      end
      if (err_set) err_flag <= 1'b1;
    end
  end

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      OFS_WIN_HI: hst_rdata = win_hi;
      OFS_WIN_LO: hst_rdata = win_lo;
      OFS_STAT: begin
        hst_rdata[STAT_ERR_BIT]  = err_flag;
        hst_rdata[STAT_BUSY_BIT] = busy;
      end
      default: hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sib_cmd_engine.sv
module sib_cmd_engine
  import sib_pkg::*;
#(
  parameter logic [31:0] ENG_BASE = 32'h0007_0000,
  parameter int          ENG_REGS = 10,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_fire,
  input  logic [31:0]      cmd_word,
  input  logic [31:0]      win_hi,
  input  logic [31:0]      win_lo,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [IDX_W-1:0] req_idx,
  output logic [63:0]      req_wdata,
  input  logic             rsp_valid,
  input  logic [63:0]      rsp_rdata,
  output logic             busy,
  output logic             err_set,
  output logic             load_en,
  output logic [63:0]      load_data
);
  localparam logic [31:0] ENG_LIMIT = ENG_BASE + 32'(ENG_REGS);

  sib_state_e  state;
  logic [31:0] tgt;
  logic [31:0] rel;
  logic        in_range;
  logic        accept;

  assign tgt      = {1'b0, cmd_word[30:0]};
  assign rel      = tgt - ENG_BASE;
  assign in_range = (tgt >= ENG_BASE) && (tgt < ENG_LIMIT);
  assign accept   = cmd_fire && (state == ST_IDLE);
  assign err_set  = accept && !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_write <= 1'b0;
      req_idx   <= '0;
      req_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept && in_range) begin
          req_write <= cmd_word[CMD_WR_BIT];
          req_idx   <= rel[IDX_W-1:0];
          req_wdata <= {win_hi, win_lo};
          state     <= ST_ISSUE;
        end
        ST_ISSUE: if (req_ready) state <= req_write ? ST_IDLE : ST_AWAIT;
        ST_AWAIT: if (rsp_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state == ST_ISSUE);
  assign busy      = (state != ST_IDLE);
  assign load_en   = (state == ST_AWAIT) && rsp_valid;
  assign load_data = rsp_rdata;
endmodule

// File: rtl/sib_bridge.sv
module sib_bridge
  import sib_pkg::*;
#(
  parameter logic [31:0] ENG_BASE = 32'h0007_0000,
  parameter int          ENG_REGS = 10,
  parameter int          IDX_W    = $clog2(ENG_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_wr,
  input  logic [5:0]       hst_addr,
  input  logic [31:0]      hst_wdata,
  output logic [31:0]      hst_rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [IDX_W-1:0] req_idx,
  output logic [63:0]      req_wdata,
  input  logic             rsp_valid,
  input  logic [63:0]      rsp_rdata
);
  logic        busy, err_set, load_en, err_flag, cmd_fire;
  logic [63:0] load_data;
  logic [31:0] win_hi, win_lo, cmd_word;

  sib_host_regs u_regs (
    .clk, .rst_n, .hst_wr, .hst_addr, .hst_wdata, .hst_rdata,
    .busy, .err_set, .load_en, .load_data,
    .win_hi, .win_lo, .err_flag, .cmd_fire, .cmd_word
  );

  sib_cmd_engine #(.ENG_BASE(ENG_BASE), .ENG_REGS(ENG_REGS), .IDX_W(IDX_W)) u_cmd (
    .clk, .rst_n, .cmd_fire, .cmd_word, .win_hi, .win_lo,
    .req_valid, .req_ready, .req_write, .req_idx, .req_wdata,
    .rsp_valid, .rsp_rdata, .busy, .err_set, .load_en, .load_data
  );
endmodule

// File: rtl/sib_checker.sv
module sib_checker
  import sib_pkg::*;
#(
  parameter logic [31:0] ENG_BASE = 32'h0007_0000,
  parameter int          ENG_REGS = 10,
  parameter int          IDX_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_wr,
  input logic [5:0]       hst_addr,
  input logic [31:0]      hst_wdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [IDX_W-1:0] req_idx,
  input logic [63:0]      req_wdata,
  input logic             rsp_valid,
  input logic [63:0]      rsp_rdata,
  input logic             busy,
  input logic             err_flag,
  input logic [31:0]      win_hi,
  input logic [31:0]      win_lo
);
  logic [31:0] tgt;
  logic        bad_cmd, clr_wr, cmd_wr;
  assign tgt     = {1'b0, hst_wdata[30:0]};
  assign cmd_wr  = hst_wr && hst_addr == OFS_CMD;
  assign clr_wr  = hst_wr && hst_addr == OFS_CLR;
  assign bad_cmd = cmd_wr && !busy &&
                   ((tgt < ENG_BASE) || (tgt >= ENG_BASE + 32'(ENG_REGS)));

  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_idx) &&
                                $stable(req_wdata) && $stable(req_write));
  a_r5_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  a_r5_ignore_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> err_flag == $past(err_flag));
  a_r6_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> !req_valid && !busy && err_flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !err_flag && win_hi == 32'h0 && win_lo == 32'h0);
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_valid && rsp_valid && !clr_wr |=>
      win_hi == $past(rsp_rdata[63:32]) && win_lo == $past(rsp_rdata[31:0]));
endmodule

bind sib_bridge sib_checker #(.ENG_BASE(ENG_BASE), .ENG_REGS(ENG_REGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_idx(req_idx),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .busy(busy), .err_flag(err_flag), .win_hi(win_hi), .win_lo(win_lo)
);

// File: tb/tb_sib_bridge.sv
module tb_sib_bridge;
  localparam logic [31:0] BASE = 32'h0007_0000;
  localparam int NREG = 10;
  localparam int IW = $clog2(NREG);

  logic clk = 0, rst_n = 0;
  logic hst_wr = 0;
  logic [5:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata;
  logic req_valid, req_write, req_ready = 0, rsp_valid = 0;
  logic [IW-1:0] req_idx;
  logic [63:0] req_wdata, rsp_rdata = 0;

  int n_chk = 0, n_bad = 0, req_count = 0;
  bit ready_en = 1, done = 0;
  logic [63:0] mem [NREG];
  bit pend = 0; int cnt = 0; int pidx = 0;

  always #4 clk = ~clk;

  sib_bridge dut (.*);

  // engine model: decides at negedge what happens at the next posedge
  always @(negedge clk) begin
    rsp_valid = 0;
    if (pend) begin
      if (cnt == 0) begin rsp_valid = 1; rsp_rdata = mem[pidx]; pend = 0; end
      else cnt--;
    end
    req_ready = ready_en;
    if (rst_n && req_valid && req_ready) begin
      req_count++;
      if (req_write) mem[req_idx] = req_wdata;
      else begin pend = 1; cnt = 2; pidx = int'(req_idx); end
    end
  end

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); hst_addr = a; #1 d = hst_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 50; i++) begin
      rd(6'h1C, s);
      if (!s[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h1C, d); check("R1 status", d, 0);
    rd(6'h00, d); check("R1 upper", d, 0);
    rd(6'h04, d); check("R1 lower", d, 0);
    check("R1 req_valid", req_valid, 0);
  endtask

  task automatic t_windows();
    logic [31:0] d;
    wr(6'h00, 32'h1111_2222); wr(6'h04, 32'h3333_4444);
    rd(6'h00, d); check("R2 upper", d, 32'h1111_2222);
    rd(6'h04, d); check("R2 lower", d, 32'h3333_4444);
    wr(6'h20, 32'hFFFF_FFFF); wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h20, d); check("R9 irq offset", d, 0);
    rd(6'h10, d); check("R9 unassigned", d, 0);
    rd(6'h00, d); check("R9 upper kept", d, 32'h1111_2222);
    rd(6'h1C, d); check("R9 status kept", d, 0);
  endtask

  task automatic t_write_cmd();
    int c0;
    wr(6'h00, 32'hDEAD_BEEF); wr(6'h04, 32'h0123_4567);
    check("R3 no commit before cmd", mem[3], {32'hC0DE_0003, 32'h1234_0003});
    c0 = req_count;
    wr(6'h08, 32'h8000_0000 | (BASE + 3));
    wr(6'h00, 32'h5555_5555); // restaging after command must not alter it
    wait_idle();
    check("R3 committed", mem[3], 64'hDEAD_BEEF_0123_4567);
    check("R3 one request", req_count - c0, 1);
  endtask

  task automatic t_read_cmd(int idx);
    logic [31:0] d;
    wr(6'h08, BASE + idx);
    rd(6'h1C, d); check("R5 busy after read cmd", d[0], 1);
    wait_idle();
    rd(6'h00, d); check("R4 upper half", d, mem[idx][63:32]);
    rd(6'h04, d); check("R4 lower half", d, mem[idx][31:0]);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d; int c0;
    logic [63:0] m6;
    m6 = mem[6]; c0 = req_count;
    ready_en = 0;
    wr(6'h08, BASE + 5);
    wr(6'h08, 32'h8000_0000 | (BASE + 6));
    wr(6'h08, BASE + 60);
    repeat (3) @(negedge clk);
    check("R8 valid held", req_valid, 1);
    check("R8 index held", req_idx, 5);
    rd(6'h1C, d); check("R5 busy, no error", d, 32'h1);
    ready_en = 1;
    wait_idle();
    check("R5 single request", req_count - c0, 1);
    check("R5 ignored write", mem[6], m6);
    rd(6'h04, d); check("R4 read after stall", d, mem[5][31:0]);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d; int c0;
    c0 = req_count;
    wr(6'h08, 32'h8000_0000 | (BASE + NREG));
    rd(6'h1C, d); check("R6 error above range", d, 32'h8000_0000);
    wr(6'h08, BASE - 1);
    check("R6 no request", req_count - c0, 0);
    t_read_cmd(2);
    rd(6'h1C, d); check("R7 sticky error", d, 32'h8000_0000);
  endtask

  task automatic t_clear();
    logic [31:0] d; logic [63:0] m3;
    m3 = mem[3];
    wr(6'h18, 32'h0);
    rd(6'h1C, d); check("R7 error cleared", d, 0);
    rd(6'h00, d); check("R7 upper cleared", d, 0);
    rd(6'h04, d); check("R7 lower cleared", d, 0);
    check("R7 engine untouched", mem[3], m3);
    t_read_cmd(3);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mem[i] = {32'hC0DE_0000 + i, 32'h1234_0000 + i};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_windows();
    t_write_cmd();
    t_read_cmd(3);
    t_read_cmd(7);
    t_busy_ignore();
    t_bad_addr();
    t_clear();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule